// File: doc/BRIEF.md
# Staged Boot Controller Register File

This block is the device-side sequencer for a staged boot. It tracks the device's boot stage: fault, first-stage loader, second-stage loader or running application. It also serves the register file through which a host controls the device and reads its state. A command decoder ahead of the block turns host transactions into a register index with separate read and write strobes. The block advances or resets the stage on writes to its command register. On reads it returns values, and some of those values are visible only in particular stages or only when enable bits are set.

The block receives several levels from elsewhere in the device: a boot-fault flag, the verification results for the application image and for the serial flash image, the write-protect state, an application version word, and one result word per feature engine. Flash programming and the feature engines themselves sit outside this block. Read data is registered and is due on the clock edge after the read strobe.

Top module: `boot_stage_regs`

## Requirements
- R1: While `rst` is high, the stage is loaded from `boot_fault`: fault (code 0) when the flag is set, otherwise stage0 (code 1). Stage codes are 0 fault, 1 stage0, 2 stage1, 3 application.
- R2: A write to the command register (index 3) with bit0 (reset) set puts the stage in stage0 on the next edge, whatever the current stage and whatever the other bits.
- R3: With bit0 clear and bit1 (launch) set, a command write moves stage0 to stage1 and has no effect in any other stage. When launch is set, bit2 is not considered.
- R4: With bits 0 and 1 clear and bit2 (enable) set, a command write moves stage1 to application and has no effect in any other stage.
- R5: On every stage entry, including reset and a reset command, the bank-ready register (index 5) is loaded with 0x0001 for stage0, 0x0002 for stage1, and 0 for fault or application.
- R6: The magic register (index 0) reads the MAGIC parameter. The hardware revision register (index 1) reads 0x0101 in stage0 and 0 in every other stage.
- R7: The application version register (index 4) reads `app_version` only in stage0 with `app_verified` high. In all other cases it reads 0.
- R8: The status register (index 2) reads 0x0002 in the fault stage. In any other stage it reads bit0 set, plus bit2 if the application is verified or else bit3, plus bit4 if write protect is on or else bit5. Stage1 adds bit6, and also bit8 if the SPI image is verified or else bit9. The application stage adds bit7.
- R9: A write to the feature-enable register (index 6) stores the whole data word. Feature result register 7+i reads bit15 set ORed with result i when bit i of that mask is set, and reads 0 otherwise.
- R10: Reads of the command register, the feature-enable register and any index without a listed register return 0. Writes to indices other than 3 and 6 change no state.
- R11: `rd_data` updates on the edge that samples `rd_en` high, reflecting the state before any write sampled on the same edge. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | IDX_W | Register index from the command decoder |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| boot_fault | input | 1 | Boot fault flag, sampled during reset |
| app_verified | input | 1 | Application image verified |
| spi_verified | input | 1 | Serial flash image verified |
| wp_on | input | 1 | Write protect enabled |
| app_version | input | DATA_W | Application version word |
| feat_result | input | NUM_FEAT*(DATA_W-1) | Result words, feature i in slice i |
| stage | output | 2 | Current stage code |

## Verification
A command write takes effect on the next edge: `stage` changes one cycle after the strobe, and a read issued in that same cycle still returns values for the old stage. Read data is due one edge after `rd_en`. The bench drives each operation after a falling edge, predicts the read value from its own stage model before the rising edge, moves its model forward at that edge, and compares both `rd_data` and `stage` at the following falling edge. Random sequences mix every index with random status inputs. Directed sequences cover the priority between command bits and commands given in the wrong stage.

// File: rtl/boot_regs_pkg.sv
package boot_regs_pkg;

  typedef enum logic [1:0] {
    ST_FAULT = 2'd0,
    ST_S0    = 2'd1,
    ST_S1    = 2'd2,
    ST_APP   = 2'd3
  } stage_e;

  // register indices
  localparam int IX_MAGIC   = 0;
  localparam int IX_HWREV   = 1;
  localparam int IX_STATUS  = 2;
  localparam int IX_CMD     = 3;
  localparam int IX_VERSION = 4;
  localparam int IX_BANK    = 5;
  localparam int IX_FEAT_EN = 6;
  localparam int IX_FEAT0   = 7;

  // command bits, listed in priority order
  localparam int CB_RESET  = 0;
  localparam int CB_LAUNCH = 1;
  localparam int CB_ENABLE = 2;

  // status word bit positions
  localparam int SB_OK      = 0;
  localparam int SB_FAULT   = 1;
  localparam int SB_APP_OK  = 2;
  localparam int SB_APP_BAD = 3;
  localparam int SB_WP_ON   = 4;
  localparam int SB_WP_OFF  = 5;
  localparam int SB_STAGE1  = 6;
  localparam int SB_APPL    = 7;
  localparam int SB_SPI_OK  = 8;
  localparam int SB_SPI_BAD = 9;

  localparam logic [15:0] HW_REV_S0 = 16'h0101;

  function automatic logic [15:0] bank_on_entry(stage_e s);
    case (s)
      ST_S0:   return 16'h0001;
      ST_S1:   return 16'h0002;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/boot_stage_fsm.sv
module boot_stage_fsm
  import boot_regs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_fault,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  output stage_e            stage_q,
  output logic [DATA_W-1:0] bank_q
);

  stage_e next_stage;
  logic   load;

  always_comb begin
    next_stage = stage_q;
    if (cmd_data[CB_RESET])
      next_stage = ST_S0;
    else if (cmd_data[CB_LAUNCH]) begin
      if (stage_q == ST_S0) next_stage = ST_S1;
    end else if (cmd_data[CB_ENABLE]) begin
      if (stage_q == ST_S1) next_stage = ST_APP;
    end
    load = cmd_wr && (cmd_data[CB_RESET] || next_stage != stage_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= boot_fault ? ST_FAULT : ST_S0;
      bank_q  <= DATA_W'(bank_on_entry(boot_fault ? ST_FAULT : ST_S0));
    end else if (load) begin
      stage_q <= next_stage;
      bank_q  <= DATA_W'(bank_on_entry(next_stage));
    end
  end

  // R1: stage after reset follows the fault flag
  a_r1_reset_stage: assert property (@(posedge clk)
    $fell(rst) |-> stage_q == ($past(boot_fault) ? ST_FAULT : ST_S0));

  // R2: reset command always lands in stage0
  a_r2_reset_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_data[CB_RESET]) |=> stage_q == ST_S0);

  // R3: stage1 is only entered from stage0
  a_r3_s1_from_s0: assert property (@(posedge clk) disable iff (rst)
    (stage_q == ST_S1 && $past(stage_q) != ST_S1) |-> $past(stage_q) == ST_S0);

  // R4: application is only entered from stage1
  a_r4_app_from_s1: assert property (@(posedge clk) disable iff (rst)
    (stage_q == ST_APP && $past(stage_q) != ST_APP) |-> $past(stage_q) == ST_S1);

  // R4: no stage changes without a command write
  a_r4_hold_no_cmd: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> $stable(stage_q));

endmodule

// File: rtl/boot_read_mux.sv
module boot_read_mux
  import boot_regs_pkg::*;
#(
  parameter int              IDX_W    = 7,
  parameter int              DATA_W   = 16,
  parameter int              NUM_FEAT = 2,
  parameter logic [DATA_W-1:0] MAGIC  = 16'h5A3C
) (
  input  logic [IDX_W-1:0]               idx,
  input  stage_e                         stage,
  input  logic [DATA_W-1:0]              bank,
  input  logic [DATA_W-1:0]              feat_mask,
  input  logic                           app_verified,
  input  logic                           spi_verified,
  input  logic                           wp_on,
  input  logic [DATA_W-1:0]              app_version,
  input  logic [NUM_FEAT*(DATA_W-1)-1:0] feat_result,
  output logic [DATA_W-1:0]              rdata
);

  localparam int RES_W = DATA_W - 1;

  logic [DATA_W-1:0] feat_word [NUM_FEAT];
  logic [DATA_W-1:0] status_w;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FEAT; gi++) begin : g_feat
      assign feat_word[gi] = feat_mask[gi]
        ? {1'b1, feat_result[gi*RES_W +: RES_W]}
        : '0;
    end
  endgenerate

  always_comb begin
    status_w = '0;
    if (stage == ST_FAULT) begin
      status_w[SB_FAULT] = 1'b1;
    end else begin
      status_w[SB_OK] = 1'b1;
      status_w[app_verified ? SB_APP_OK : SB_APP_BAD] = 1'b1;
      status_w[wp_on ? SB_WP_ON : SB_WP_OFF] = 1'b1;
      if (stage == ST_S1) begin
        status_w[SB_STAGE1] = 1'b1;
        status_w[spi_verified ? SB_SPI_OK : SB_SPI_BAD] = 1'b1;
      end
      if (stage == ST_APP) status_w[SB_APPL] = 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_W'(IX_MAGIC):   rdata = MAGIC;
      IDX_W'(IX_HWREV):   rdata = (stage == ST_S0) ? DATA_W'(HW_REV_S0) : '0;
      IDX_W'(IX_STATUS):  rdata = status_w;
      IDX_W'(IX_VERSION): rdata = (stage == ST_S0 && app_verified) ? app_version : '0;
      IDX_W'(IX_BANK):    rdata = bank;
      default: begin
        for (int i = 0; i < NUM_FEAT; i++)
          if (idx == IDX_W'(IX_FEAT0 + i)) rdata = feat_word[i];
      end
    endcase
  end

endmodule

// File: rtl/boot_stage_regs.sv
module boot_stage_regs
  import boot_regs_pkg::*;
#(
  parameter int                IDX_W    = 7,
  parameter int                DATA_W   = 16,
  parameter int                NUM_FEAT = 2,
  parameter logic [DATA_W-1:0] MAGIC    = 16'h5A3C
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [IDX_W-1:0]               reg_idx,
  input  logic                           wr_en,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           rd_en,
  output logic [DATA_W-1:0]              rd_data,
  input  logic                           boot_fault,
  input  logic                           app_verified,
  input  logic                           spi_verified,
  input  logic                           wp_on,
  input  logic [DATA_W-1:0]              app_version,
  input  logic [NUM_FEAT*(DATA_W-1)-1:0] feat_result,
  output logic [1:0]                     stage
);

  stage_e            stage_q;
  logic [DATA_W-1:0] bank_q;
  logic [DATA_W-1:0] feat_mask_q;
  logic [DATA_W-1:0] rdata_c;
  logic              cmd_wr;

  assign cmd_wr = wr_en && reg_idx == IDX_W'(IX_CMD);
  assign stage  = stage_q;

  boot_stage_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .boot_fault (boot_fault),
    .cmd_wr     (cmd_wr),
    .cmd_data   (wr_data),
    .stage_q    (stage_q),
    .bank_q     (bank_q)
  );

  boot_read_mux #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_FEAT(NUM_FEAT), .MAGIC(MAGIC)
  ) u_rmux (
    .idx          (reg_idx),
    .stage        (stage_q),
    .bank         (bank_q),
    .feat_mask    (feat_mask_q),
    .app_verified (app_verified),
    .spi_verified (spi_verified),
    .wp_on        (wp_on),
    .app_version  (app_version),
    .feat_result  (feat_result),
    .rdata        (rdata_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      feat_mask_q <= '0;
      rd_data     <= '0;
    end else begin
      if (wr_en && reg_idx == IDX_W'(IX_FEAT_EN)) feat_mask_q <= wr_data;
      if (rd_en) rd_data <= rdata_c;
    end
  end

  // R6: revision readback depends on the stage seen at the read
  a_r6_hwrev: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_idx == IDX_W'(IX_HWREV)) |=>
      rd_data == (($past(stage) == 2'd1) ? 16'h0101 : 16'h0000));

  // R11: read data holds while no read is strobed
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R8: fault stage reports only the fault bit
  a_r8_fault_status: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_idx == IDX_W'(IX_STATUS) && stage == 2'd0) |=> rd_data == 16'h0002);

endmodule

// File: tb/tb_boot_stage_regs.sv
module tb_boot_stage_regs;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 7;
  localparam int DATA_W = 16;
  localparam int NUM_FEAT = 2;
  localparam logic [15:0] MAGIC = 16'h5A3C;

  logic                           clk = 0;
  logic                           rst;
  logic [IDX_W-1:0]               reg_idx;
  logic                           wr_en, rd_en;
  logic [DATA_W-1:0]              wr_data, rd_data;
  logic                           boot_fault, app_verified, spi_verified, wp_on;
  logic [DATA_W-1:0]              app_version;
  logic [NUM_FEAT*(DATA_W-1)-1:0] feat_result;
  logic [1:0]                     stage;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  int          m_stage;
  logic [15:0] m_mask;
  logic [15:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_stage_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_FEAT(NUM_FEAT), .MAGIC(MAGIC)) dut (
    .clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .boot_fault(boot_fault),
    .app_verified(app_verified), .spi_verified(spi_verified), .wp_on(wp_on),
    .app_version(app_version), .feat_result(feat_result), .stage(stage)
  );

  function automatic logic [15:0] exp_bank(int s);
    return (s == 1) ? 16'h0001 : (s == 2) ? 16'h0002 : 16'h0000;
  endfunction

  function automatic logic [15:0] exp_status(int s);
    logic [15:0] v;
    v = 0;
    if (s == 0) return 16'h0002;
    v[0] = 1;
    if (app_verified) v[2] = 1; else v[3] = 1;
    if (wp_on) v[4] = 1; else v[5] = 1;
    if (s == 2) begin
      v[6] = 1;
      if (spi_verified) v[8] = 1; else v[9] = 1;
    end
    if (s == 3) v[7] = 1;
    return v;
  endfunction

  function automatic logic [15:0] exp_read(int idx);
    case (idx)
      0: return MAGIC;
      1: return (m_stage == 1) ? 16'h0101 : 16'h0000;
      2: return exp_status(m_stage);
      4: return (m_stage == 1 && app_verified) ? app_version : 16'h0000;
      5: return exp_bank(m_stage);
      7: return m_mask[0] ? {1'b1, feat_result[14:0]} : 16'h0000;
      8: return m_mask[1] ? {1'b1, feat_result[29:15]} : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string req_of(int idx);
    case (idx)
      0, 1: return "R6";
      2: return "R8";
      4: return "R7";
      5: return "R5";
      7, 8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation; inputs set after a falling edge, outputs checked at the next one
  task automatic op(bit rd, bit wr, int idx, logic [15:0] d, string req);
    logic [15:0] exp_r;
    int ns;
    reg_idx = IDX_W'(idx);
    rd_en = rd; wr_en = wr; wr_data = d;
    exp_r = rd ? exp_read(idx) : m_rd;
    ns = m_stage;
    if (wr && idx == 3) begin
      if (d[0]) ns = 1;
      else if (d[1]) begin if (m_stage == 1) ns = 2; end
      else if (d[2]) begin if (m_stage == 2) ns = 3; end
    end
    if (wr && idx == 6) m_mask = d;
    @(posedge clk);
    m_stage = ns;
    m_rd = exp_r;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    check(rd ? ((req == "") ? req_of(idx) : req) : "R11", rd_data, exp_r);
    check((req == "") ? "R3" : req, {14'b0, stage}, 16'(m_stage));
  endtask

  task automatic do_reset(bit f);
    boot_fault = f; rst = 1; rd_en = 0; wr_en = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_stage = f ? 0 : 1; m_mask = 0; m_rd = 0;
    check("R1", {14'b0, stage}, 16'(m_stage));
    check("R11", rd_data, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    reg_idx = 0; wr_data = 0; rd_en = 0; wr_en = 0;
    app_verified = 1; spi_verified = 0; wp_on = 1;
    app_version = 16'h0304; feat_result = {15'h1234, 15'h0567};

    // fault boot
    do_reset(1);
    op(1, 0, 2, 0, "R8");
    op(1, 0, 5, 0, "R5");
    op(0, 1, 3, 16'h0002, "R3");  // launch ignored in fault
    op(0, 1, 3, 16'h0004, "R4");  // enable ignored in fault
    op(1, 1, 3, 16'h0007, "R2");  // reset wins
    op(1, 0, 5, 0, "R5");
    op(1, 0, 1, 0, "R6");
    op(1, 0, 4, 0, "R7");
    app_verified = 0;
    op(1, 0, 4, 0, "R7");
    op(1, 0, 2, 0, "R8");
    op(0, 1, 3, 16'h0004, "R4");  // enable ignored in stage0
    op(0, 1, 3, 16'h0006, "R3");  // launch set, goes to stage1
    op(1, 0, 5, 0, "R5");
    op(1, 0, 2, 0, "R8");
    op(0, 1, 3, 16'h0006, "R3");  // launch in stage1 ignored, enable suppressed
    op(0, 1, 3, 16'h0004, "R4");  // enable -> application
    op(1, 0, 2, 0, "R8");
    op(1, 0, 5, 0, "R5");
    op(1, 0, 1, 0, "R6");
    op(1, 0, 0, 0, "R6");
    op(1, 0, 7, 0, "R9");
    op(0, 1, 6, 16'h0002, "R9");
    op(1, 0, 8, 0, "R9");
    op(1, 0, 7, 0, "R9");
    op(0, 1, 9, 16'hFFFF, "R10");  // unlisted write
    op(0, 1, 2, 16'h0001, "R10");  // write to read-only status
    op(1, 0, 2, 0, "R10");
    op(1, 0, 6, 0, "R10");
    op(1, 0, 3, 0, "R10");
    op(1, 0, 100, 0, "R10");
    op(0, 0, 0, 0, "R11");
    op(1, 1, 3, 16'h0001, "R11");  // read sees state before the reset command
    op(1, 0, 5, 0, "R5");

    // normal boot, then random traffic
    do_reset(0);
    for (int n = 0; n < 3000; n++) begin
      int idx;
      logic [15:0] d;
      app_verified = 1'($urandom);
      spi_verified = 1'($urandom);
      wp_on        = 1'($urandom);
      app_version  = 16'($urandom);
      feat_result  = 30'($urandom);
      idx = $urandom_range(0, 10);
      d = 16'($urandom);
      if (idx == 3) d = d & 16'h0007 & (($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'hFFFE);
      op(1'($urandom), ($urandom_range(0, 2) == 0), idx, d, "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule